// File: doc/BRIEF.md
# Banked 64-bit General Register File

This block holds the integer architectural state for a load/store processor core. There are thirty-one 64-bit registers, numbered 0 to 30. Each of them can be read or written either as a full 64-bit word or as a 32-bit view of its low half. Register 30 also serves as the link register, so a branch-and-link result is written to index 30 through the normal write port. Index 31 has no register behind it. On each port, a select bit decides whether index 31 means a constant-zero source and discard sink, or the stack pointer. The stack pointer has four copies, one for each of the exception levels 0 to 3, and the 2-bit level input picks which copy is accessed.

There are two read ports and one write port. Reads are combinational. Writes take effect on the rising clock edge. A read that addresses the same storage as a write in the same cycle returns the value being written (write-first). Every port carries only control and data. There is no stream traffic, so no valid/ready handshake is used and no back-pressure applies. A synchronous active-high reset clears all registers and all stack pointer copies.

Top module: `gpr_bank_file`

## Requirements
- R1: With wr_w32=0, a write to an index 0..30 stores all 64 bits of wr_data. From the next cycle, a 64-bit read (rdN_w32=0) of that index on either port returns that value.
- R2: A read with rdN_w32=1 returns bits 31:0 of the addressed value in rdN_data[31:0], with rdN_data[63:32] equal to zero.
- R3: A write with wr_w32=1 stores wr_data[31:0] in bits 31:0 of the target and clears bits 63:32, whatever the previous contents were.
- R4: Index 31 with the port's select bit at 0 is the zero register. A read there returns 0. A write there changes no register and no stack pointer copy.
- R5: Index 31 with the port's select bit at 1 accesses the stack pointer copy numbered by cur_el (0..3). The four copies are independent.
- R6: When a read addresses the same storage as an enabled write in the same cycle, the read returns the written value, including the upper-half clearing of a 32-bit write. Here "same storage" means the same index 0..30, or index 31 in stack-pointer mode on both ports.
- R7: While rst is high at a clock edge, all 31 registers and all 4 stack pointer copies become 0.
- R8: Index 30 (the link register) is ordinary storage. Writing it leaves register 29 and the current stack pointer copy unchanged.
- R9: The two read ports are independent. In the same cycle they may read different indices, widths and index-31 modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cur_el | input | 2 | Current exception level, selects stack pointer copy |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index 0..31 |
| wr_w32 | input | 1 | 1 = 32-bit write (upper half cleared) |
| wr_sp | input | 1 | 1 = index 31 is the stack pointer, 0 = zero register |
| wr_data | input | 64 | Write data |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_w32 | input | 1 | Read port 0 32-bit view |
| rd0_sp | input | 1 | Read port 0 index-31 mode |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_w32 | input | 1 | Read port 1 32-bit view |
| rd1_sp | input | 1 | Read port 1 index-31 mode |
| rd1_data | output | 64 | Read port 1 data |

## Verification
The bench writes all-ones words and then writes the 32-bit view on top of them. A design that only masked the low half, instead of clearing bits 63:32, would leave ones in the upper half. It writes index 31 in zero mode and then reads all four stack pointer copies. A design that let the discarded write reach a stack pointer would return a changed copy. Random traffic with frequent same-cycle read/write collisions checks the write-first path, including collisions between a 32-bit write and a 64-bit read. A stale bypass would return the old value there, or an unmasked upper half. Switching cur_el between writes and reads exposes a stack pointer that is not banked, or banked by the wrong level.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int IDX_W   = 5;
  localparam int NUM_GPR = (1 << IDX_W) - 1;
  localparam int ZR_IDX  = NUM_GPR;
  localparam int LINK_IDX = NUM_GPR - 1;
  localparam int EL_W    = 2;
  localparam int NUM_EL  = 1 << EL_W;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             w32;
    logic             sp;
  } rd_req_t;
endpackage

// File: rtl/gprf_wr_decode.sv
module gprf_wr_decode
  import gprf_pkg::*;
(
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_w32,
  input  logic                  wr_sp,
  input  word_t                 wr_data,
  input  logic [EL_W-1:0]       cur_el,
  output logic [NUM_GPR-1:0]    gpr_we,
  output logic [NUM_EL-1:0]     sp_we,
  output word_t                 wval
);
  logic to_r31;
  assign to_r31 = (wr_idx == IDX_W'(ZR_IDX));

  // 32-bit writes clear the upper half
  assign wval = wr_w32 ? {{(DATA_W-HALF_W){1'b0}}, wr_data[HALF_W-1:0]} : wr_data;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gwe
    assign gpr_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  // index 31 in zero mode drives no enable at all
  for (genvar e = 0; e < NUM_EL; e++) begin : g_swe
    assign sp_we[e] = wr_en && to_r31 && wr_sp && (cur_el == EL_W'(e));
  end
endmodule

// File: rtl/gprf_store.sv
module gprf_store
  import gprf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GPR-1:0]             gpr_we,
  input  logic [NUM_EL-1:0]              sp_we,
  input  word_t                          wval,
  output logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
  output logic [NUM_EL-1:0][DATA_W-1:0]  sp_q
);
  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)            gpr_q[g] <= '0;
      else if (gpr_we[g]) gpr_q[g] <= wval;
    end
  end

  for (genvar e = 0; e < NUM_EL; e++) begin : g_sp
    always_ff @(posedge clk) begin
      if (rst)           sp_q[e] <= '0;
      else if (sp_we[e]) sp_q[e] <= wval;
    end
  end
endmodule

// File: rtl/gprf_rd_port.sv
module gprf_rd_port
  import gprf_pkg::*;
(
  input  rd_req_t                        req,
  input  logic [EL_W-1:0]                cur_el,
  input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
  input  logic [NUM_EL-1:0][DATA_W-1:0]  sp_q,
  input  logic [NUM_GPR-1:0]             gpr_we,
  input  logic [NUM_EL-1:0]              sp_we,
  input  word_t                          wval,
  output word_t                          rdata
);
  logic  is_r31;
  logic  hit;
  word_t stored;
  word_t full;

  assign is_r31 = (req.idx == IDX_W'(ZR_IDX));

  always_comb begin
    if (is_r31) begin
      stored = sp_q[cur_el];
      hit    = req.sp && sp_we[cur_el];
    end else begin
      stored = gpr_q[req.idx];
      hit    = gpr_we[req.idx];
    end
  end

  always_comb begin
    if (is_r31 && !req.sp) full = '0;
    else if (hit)          full = wval;
    else                   full = stored;
  end

  assign rdata = req.w32 ? {{(DATA_W-HALF_W){1'b0}}, full[HALF_W-1:0]} : full;
endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file
  import gprf_pkg::*;
#(
  parameter int NUM_RD = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EL_W-1:0]    cur_el,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_w32,
  input  logic               wr_sp,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd0_idx,
  input  logic               rd0_w32,
  input  logic               rd0_sp,
  output logic [DATA_W-1:0]  rd0_data,
  input  logic [IDX_W-1:0]   rd1_idx,
  input  logic               rd1_w32,
  input  logic               rd1_sp,
  output logic [DATA_W-1:0]  rd1_data
);
  logic [NUM_GPR-1:0]             gpr_we;
  logic [NUM_EL-1:0]              sp_we;
  word_t                          wval;
  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
  logic [NUM_EL-1:0][DATA_W-1:0]  sp_q;
  rd_req_t [NUM_RD-1:0]           rreq;
  logic [NUM_RD-1:0][DATA_W-1:0]  rdat;

  assign rreq[0] = '{idx: rd0_idx, w32: rd0_w32, sp: rd0_sp};
  assign rreq[1] = '{idx: rd1_idx, w32: rd1_w32, sp: rd1_sp};
  assign rd0_data = rdat[0];
  assign rd1_data = rdat[1];

  gprf_wr_decode u_dec (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_w32(wr_w32), .wr_sp(wr_sp),
    .wr_data(wr_data), .cur_el(cur_el),
    .gpr_we(gpr_we), .sp_we(sp_we), .wval(wval)
  );

  gprf_store u_store (
    .clk(clk), .rst(rst), .gpr_we(gpr_we), .sp_we(sp_we), .wval(wval),
    .gpr_q(gpr_q), .sp_q(sp_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gprf_rd_port u_rd (
      .req(rreq[p]), .cur_el(cur_el), .gpr_q(gpr_q), .sp_q(sp_q),
      .gpr_we(gpr_we), .sp_we(sp_we), .wval(wval), .rdata(rdat[p])
    );
  end
endmodule

// File: rtl/gprf_chk.sv
module gprf_chk
  import gprf_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [EL_W-1:0]    cur_el,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               wr_w32,
  input logic               wr_sp,
  input logic [DATA_W-1:0]  wr_data,
  input logic [IDX_W-1:0]   rd0_idx,
  input logic               rd0_w32,
  input logic               rd0_sp,
  input logic [DATA_W-1:0]  rd0_data,
  input logic [IDX_W-1:0]   rd1_idx,
  input logic               rd1_w32,
  input logic               rd1_sp,
  input logic [DATA_W-1:0]  rd1_data
);
  localparam logic [IDX_W-1:0] R31 = IDX_W'(ZR_IDX);

  assert_zero_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == R31 && !rd0_sp) |-> (rd0_data == '0));

  assert_half_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd1_w32 |-> (rd1_data[DATA_W-1:HALF_W] == '0));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_w32 && !rd0_w32 && wr_idx != R31 && rd0_idx == wr_idx)
      |-> (rd0_data == wr_data));

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !wr_w32 && wr_idx != R31) && rd0_idx == $past(wr_idx)
      && !rd0_w32 && !(wr_en && wr_idx == rd0_idx)) |-> (rd0_data == $past(wr_data)));

  assert_upper_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && wr_w32 && wr_idx != R31) && rd1_idx == $past(wr_idx)
      && !(wr_en && wr_idx == rd1_idx)) |-> (rd1_data[DATA_W-1:HALF_W] == '0));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wr_en) |-> (rd0_data == '0 && rd1_data == '0));
endmodule

bind gpr_bank_file gprf_chk u_chk (.*);

// File: tb/tb_gpr_bank_file.sv
module tb_gpr_bank_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cur_el = '0;
  logic        wr_en = 1'b0, wr_w32 = 1'b0, wr_sp = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd0_idx = '0, rd1_idx = '0;
  logic        rd0_w32 = 1'b0, rd0_sp = 1'b0, rd1_w32 = 1'b0, rd1_sp = 1'b0;
  logic [63:0] rd0_data, rd1_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_gpr [31];
  logic [63:0] m_sp  [4];

  always #2 clk = ~clk;

  gpr_bank_file dut (
    .clk(clk), .rst(rst), .cur_el(cur_el),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_w32(wr_w32), .wr_sp(wr_sp), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_w32(rd0_w32), .rd0_sp(rd0_sp), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_w32(rd1_w32), .rd1_sp(rd1_sp), .rd1_data(rd1_data)
  );

  function automatic logic [63:0] wr_value();
    return wr_w32 ? {32'h0, wr_data[31:0]} : wr_data;
  endfunction

  function automatic bit wr_hits(input logic [4:0] idx, input logic sp);
    if (!wr_en || wr_idx != idx) return 1'b0;
    if (idx != 5'd31) return 1'b1;
    return sp && wr_sp;
  endfunction

  function automatic logic [63:0] exp_read(input logic [4:0] idx, input logic w32, input logic sp);
    logic [63:0] v;
    if (idx == 5'd31 && !sp) return 64'h0;
    v = (idx == 5'd31) ? m_sp[cur_el] : m_gpr[idx];
    if (wr_hits(idx, sp)) v = wr_value();
    return w32 ? {32'h0, v[31:0]} : v;
  endfunction

  function automatic string auto_tag(input logic [4:0] idx, input logic w32, input logic sp);
    if (idx == 5'd31 && !sp) return "R4";
    if (wr_hits(idx, sp)) return "R6";
    if (idx == 5'd31) return "R5";
    if (w32) return "R2";
    return "R1";
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    for (int e = 0; e < 4; e++) m_sp[e] = '0;
  endtask

  task automatic model_update();
    if (wr_en) begin
      if (wr_idx != 5'd31) m_gpr[wr_idx] = wr_value();
      else if (wr_sp) m_sp[cur_el] = wr_value();
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [4:0] widx,
                      input logic ww32, input logic wsp, input logic [63:0] wd,
                      input logic [1:0] el,
                      input logic [4:0] i0, input logic w0, input logic s0,
                      input logic [4:0] i1, input logic w1, input logic s1);
    string t0, t1;
    @(negedge clk);
    wr_en = we; wr_idx = widx; wr_w32 = ww32; wr_sp = wsp; wr_data = wd; cur_el = el;
    rd0_idx = i0; rd0_w32 = w0; rd0_sp = s0;
    rd1_idx = i1; rd1_w32 = w1; rd1_sp = s1;
    #1;
    t0 = (tag == "") ? auto_tag(i0, w0, s0) : tag;
    t1 = (tag == "") ? auto_tag(i1, w1, s1) : tag;
    check(t0, "rd0", rd0_data, exp_read(i0, w0, s0));
    check(t1, "rd1", rd1_data, exp_read(i1, w1, s1));
    model_update();
  endtask

  task automatic idle_read(input string tag, input logic [1:0] el,
                           input logic [4:0] i0, input logic w0, input logic s0,
                           input logic [4:0] i1, input logic w1, input logic s1);
    step(tag, 1'b0, 5'd0, 1'b0, 1'b0, 64'h0, el, i0, w0, s0, i1, w1, s1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    // dirty the state before reset so R7 clearing is observable
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd3; wr_data = 64'hDEAD_BEEF_0000_1111;
    @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();

    // R7: everything reads zero after reset
    for (int i = 0; i < 31; i += 2)
      idle_read("R7", 2'd0, 5'(i), 1'b0, 1'b0, 5'(i + 1), 1'b0, 1'b0);
    for (int e = 0; e < 4; e++)
      idle_read("R7", 2'(e), 5'd31, 1'b0, 1'b1, 5'd31, 1'b0, 1'b1);

    // R1: full 64-bit write and read back on both ports
    step("R1", 1'b1, 5'd7, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 2'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    idle_read("R1", 2'd0, 5'd7, 1'b0, 1'b0, 5'd7, 1'b0, 1'b0);

    // R3: 32-bit write over all-ones clears upper half
    step("R3", 1'b1, 5'd5, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    step("R3", 1'b1, 5'd5, 1'b1, 1'b0, 64'hAAAA_AAAA_1234_5678, 2'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    idle_read("R3", 2'd0, 5'd5, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0);

    // R2: 32-bit read of a full value
    idle_read("R2", 2'd0, 5'd7, 1'b1, 1'b0, 5'd7, 1'b0, 1'b0);

    // R5: four independent stack pointer copies
    for (int e = 0; e < 4; e++)
      step("R5", 1'b1, 5'd31, 1'b0, 1'b1, 64'h5000_0000_0000_0000 + 64'(e * 16 + 8),
           2'(e), 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    for (int e = 0; e < 4; e++)
      idle_read("R5", 2'(e), 5'd31, 1'b0, 1'b1, 5'd31, 1'b1, 1'b1);

    // R4: zero-mode write is discarded, zero-mode read gives 0
    for (int e = 0; e < 4; e++)
      step("R4", 1'b1, 5'd31, 1'b0, 1'b0, 64'hFFFF_0000_FFFF_0000, 2'(e),
           5'd31, 1'b0, 1'b0, 5'd31, 1'b0, 1'b0);
    for (int e = 0; e < 4; e++)
      idle_read("R4", 2'(e), 5'd31, 1'b0, 1'b1, 5'd31, 1'b0, 1'b0);

    // R6: same-cycle bypass, 32-bit write seen by 64-bit read, and SP bypass
    step("R6", 1'b1, 5'd5, 1'b1, 1'b0, 64'hFFFF_FFFF_CAFE_F00D, 2'd1, 5'd5, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0);
    step("R6", 1'b1, 5'd31, 1'b0, 1'b1, 64'h7777_6666_5555_4444, 2'd2, 5'd31, 1'b0, 1'b1, 5'd31, 1'b0, 1'b1);

    // R8: link register write leaves r29 and SP unchanged
    step("R8", 1'b1, 5'd30, 1'b0, 1'b0, 64'h0000_0040_0000_1234, 2'd3, 5'd29, 1'b0, 1'b0, 5'd31, 1'b0, 1'b1);
    idle_read("R8", 2'd3, 5'd30, 1'b0, 1'b0, 5'd29, 1'b0, 1'b0);
    idle_read("R8", 2'd3, 5'd31, 1'b0, 1'b1, 5'd30, 1'b1, 1'b0);

    // R9: ports read different indices, widths and modes together
    idle_read("R9", 2'd2, 5'd7, 1'b1, 1'b0, 5'd31, 1'b0, 1'b1);
    idle_read("R9", 2'd0, 5'd31, 1'b0, 1'b0, 5'd30, 1'b0, 1'b0);

    // random traffic with frequent collisions
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] wi, i0, i1;
      logic [63:0] d;
      wi = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 8 + (($urandom % 2) ? 23 : 0));
      i0 = ($urandom % 3 == 0) ? wi : 5'($urandom % 32);
      i1 = ($urandom % 3 == 0) ? wi : 5'($urandom % 32);
      d  = {$urandom, $urandom};
      step("", 1'($urandom % 4 != 0), wi, 1'($urandom), 1'($urandom), d, 2'($urandom),
           i0, 1'($urandom), 1'($urandom), i1, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule